// File: doc/BRIEF.md
# Outstanding Miss Tracker

This block keeps a record of memory requests that a processor port has sent toward a cache controller and that have not completed yet. Every record is keyed by the cache-line address of the request. When a new request arrives, the block compares its line against all live records in a single cycle. It then does one of three things: it issues the request, it rejects the request because the line is already in flight, or it rejects the request because no room is left. Issued requests go out on a downstream issue port in the same cycle.

Records are held in two independent sets. Plain loads and instruction fetches go into the read-class set. Stores and every atomic or locked operation go into the write-class set. Completions arrive as separate read and write responses, and each response retires the record for its line in the matching set.

A free-running cycle counter stamps each record when it is allocated. An age watchdog raises a sticky deadlock flag when any record stays in flight too long. Four saturating counters record rejected attempts, split by the class of the new request and the class of the record it collided with.

Top module: `miss_tracker`

## Requirements
- R1: Request type codes are 0 load and 1 instruction fetch, which are read-class, and 2 store, 3 read-modify-write read, 4 read-modify-write write, 5 locked read and 6 locked write, which are write-class. An issued request is presented on issueType unchanged and on issueLine as its byte address shifted right by 4.
- R2: A legal request whose line matches any live record in either set gets status 2 (aliased), whatever its type, and is not issued.
- R3: A legal request with no match gets status 3 (full) and is not issued when outCount is at least 6, or when its own set has no free record (4 per set).
- R4: Any other legal request gets status 1 (issued), and issueValid is high in the same cycle. outCount is one higher after the clock edge, unless a response retires a record in that same cycle.
- R5: outCount always equals the number of live records across both sets. Reset clears every record and sets outCount to 0.
- R6: A request whose byte offset (address bits 3:0) plus reqLen exceeds 16 raises reqIllegal, gets status 0 and is not issued. This check takes precedence over aliasing.
- R7: A read response retires the read-class record for its line, and a write response retires the write-class record for its line. outCount drops by one, and the line can then be issued again.
- R8: A response that has no live record for its line in its own set raises rspError in the same cycle and changes no state.
- R9: deadlock rises once any live record reaches an age of 200 cycles, and it stays high until reset, even after that record retires.
- R10: Each aliased rejection increments exactly one saturating counter. A match in the write-class set is attributed first. The counter is chosen by the new request's class: aliasRdOnWr, aliasWrOnWr, aliasRdOnRd or aliasWrOnRd.
- R11: When reqValid is low, reqStatus is 0 and issueValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | New request present |
| reqType | input | 3 | Request type code |
| reqAddr | input | 16 | Request byte address |
| reqLen | input | 5 | Request length in bytes |
| reqStatus | output | 2 | 0 none/illegal, 1 issued, 2 aliased, 3 full |
| reqIllegal | output | 1 | Request crosses the line boundary |
| issueValid | output | 1 | Request forwarded downstream this cycle |
| issueLine | output | 12 | Line address of forwarded request |
| issueType | output | 3 | Type of forwarded request |
| rdRspValid | input | 1 | Read-class completion |
| rdRspLine | input | 12 | Line of read completion |
| wrRspValid | input | 1 | Write-class completion |
| wrRspLine | input | 12 | Line of write completion |
| rspError | output | 1 | Completion with no matching record |
| deadlock | output | 1 | Sticky over-age flag |
| outCount | output | 4 | Number of records in flight |
| aliasRdOnWr | output | 8 | Read-class request blocked by write record |
| aliasWrOnWr | output | 8 | Write-class request blocked by write record |
| aliasRdOnRd | output | 8 | Read-class request blocked by read record |
| aliasWrOnRd | output | 8 | Write-class request blocked by read record |

## Verification
Several properties are checked on every cycle:
- outCount matches the live records in both sets.
- An allocation never lands on a line already live in its set.
- A rejected request is never issued.
- A fresh issue raises the count by one.
- The deadlock flag never falls.

Some behaviour can only be shown by the bench's scenarios: the class chosen for each type code, the alias counter selected, the exact edge between legal and illegal lengths, the per-set capacity limit against the global limit, and the watchdog firing only after the age limit.

// File: rtl/mtk_pkg.sv
package mtk_pkg;

  typedef enum logic [2:0] {
    RT_LOAD    = 3'd0,
    RT_IFETCH  = 3'd1,
    RT_STORE   = 3'd2,
    RT_RMW_RD  = 3'd3,
    RT_RMW_WR  = 3'd4,
    RT_LOCK_RD = 3'd5,
    RT_LOCK_WR = 3'd6,
    RT_SPARE   = 3'd7
  } reqType_e;

  typedef enum logic [1:0] {
    ST_NONE    = 2'd0,
    ST_ISSUED  = 2'd1,
    ST_ALIASED = 2'd2,
    ST_FULL    = 2'd3
  } reqStatus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic allocRd;
    logic allocWr;
    logic retireRd;
    logic retireWr;
  } ctlStrobes_t;

  // alias counter slots
  localparam int AC_RD_ON_WR = 0;
  localparam int AC_WR_ON_WR = 1;
  localparam int AC_RD_ON_RD = 2;
  localparam int AC_WR_ON_RD = 3;
  localparam int AC_NUM      = 4;

  function automatic logic isWriteClass(input logic [2:0] t);
    return !(t == RT_LOAD || t == RT_IFETCH);
  endfunction

endpackage

// File: rtl/mtk_entry_set.sv
module mtk_entry_set #(
  parameter int ENTRIES   = 4,
  parameter int LINE_W    = 12,
  parameter int AGE_W     = 16,
  parameter int AGE_LIMIT = 200
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LINE_W-1:0]  lookupLine,
  input  logic [LINE_W-1:0]  retireLine,
  input  logic               allocEn,
  input  logic               retireEn,
  input  logic [AGE_W-1:0]   nowCycle,
  output logic               lookupHit,
  output logic               retireHit,
  output logic               hasFree,
  output logic               agedOut,
  output logic [ENTRIES-1:0] validVec
);

  logic [ENTRIES-1:0] validQ;
  logic [LINE_W-1:0]  lineQ  [ENTRIES];
  logic [AGE_W-1:0]   stampQ [ENTRIES];
  logic [ENTRIES-1:0] lookMatch, retMatch, agedVec, freeSel;

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    assign lookMatch[g] = validQ[g] && (lineQ[g] == lookupLine);
    assign retMatch[g]  = validQ[g] && (lineQ[g] == retireLine);
    assign agedVec[g]   = validQ[g] && ((nowCycle - stampQ[g]) >= AGE_W'(AGE_LIMIT));
  end

  // first free slot, lowest index wins
  always_comb begin
    logic found;
    found   = 1'b0;
    freeSel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!validQ[i] && !found) begin
        freeSel[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign lookupHit = |lookMatch;
  assign retireHit = |retMatch;
  assign hasFree   = ~&validQ;
  assign agedOut   = |agedVec;
  assign validVec  = validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (retireEn && retMatch[i]) validQ[i] <= 1'b0;
        if (allocEn && freeSel[i])   validQ[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (allocEn && freeSel[i]) begin
        lineQ[i]  <= lookupLine;
        stampQ[i] <= nowCycle;
      end
    end
  end

  // R2: control never allocates a line already live here, nor into a full set
  p_alloc_fresh_r2: assert property (@(posedge clk) disable iff (!rstN)
    allocEn |-> (!lookupHit && hasFree));

  // R7: a retired record is gone on the next cycle
  p_retire_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (retireEn && retireHit && !allocEn) |=> ($countones(validQ) == $countones($past(validQ)) - 1));

endmodule

// File: rtl/mtk_datapath.sv
module mtk_datapath
  import mtk_pkg::*;
#(
  parameter int RD_ENTRIES = 4,
  parameter int WR_ENTRIES = 4,
  parameter int LINE_W     = 12,
  parameter int AGE_W      = 16,
  parameter int AGE_LIMIT  = 200
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strobes,
  input  logic [LINE_W-1:0]     reqLine,
  input  logic [LINE_W-1:0]     rdRspLine,
  input  logic [LINE_W-1:0]     wrRspLine,
  output logic                  hitRd,
  output logic                  hitWr,
  output logic                  freeRd,
  output logic                  freeWr,
  output logic                  rdRetHit,
  output logic                  wrRetHit,
  output logic                  agedAny,
  output logic [RD_ENTRIES-1:0] rdValid,
  output logic [WR_ENTRIES-1:0] wrValid
);

  logic [AGE_W-1:0] nowCycle;
  logic             agedRd, agedWr;

  always_ff @(posedge clk) begin
    if (!rstN) nowCycle <= '0;
    else       nowCycle <= nowCycle + 1'b1;
  end

  mtk_entry_set #(
    .ENTRIES(RD_ENTRIES), .LINE_W(LINE_W), .AGE_W(AGE_W), .AGE_LIMIT(AGE_LIMIT)
  ) i_rdSet (
    .clk(clk), .rstN(rstN),
    .lookupLine(reqLine), .retireLine(rdRspLine),
    .allocEn(strobes.allocRd), .retireEn(strobes.retireRd),
    .nowCycle(nowCycle),
    .lookupHit(hitRd), .retireHit(rdRetHit), .hasFree(freeRd),
    .agedOut(agedRd), .validVec(rdValid)
  );

  mtk_entry_set #(
    .ENTRIES(WR_ENTRIES), .LINE_W(LINE_W), .AGE_W(AGE_W), .AGE_LIMIT(AGE_LIMIT)
  ) i_wrSet (
    .clk(clk), .rstN(rstN),
    .lookupLine(reqLine), .retireLine(wrRspLine),
    .allocEn(strobes.allocWr), .retireEn(strobes.retireWr),
    .nowCycle(nowCycle),
    .lookupHit(hitWr), .retireHit(wrRetHit), .hasFree(freeWr),
    .agedOut(agedWr), .validVec(wrValid)
  );

  assign agedAny = agedRd | agedWr;

endmodule

// File: rtl/mtk_control.sv
module mtk_control
  import mtk_pkg::*;
#(
  parameter int OFF_W      = 4,
  parameter int LEN_W      = 5,
  parameter int LINE_BYTES = 16,
  parameter int MAX_OUT    = 6,
  parameter int OCC_W      = 4,
  parameter int CNT_W      = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic [2:0]                   reqType,
  input  logic [OFF_W-1:0]             reqOffset,
  input  logic [LEN_W-1:0]             reqLen,
  input  logic                         rdRspValid,
  input  logic                         wrRspValid,
  input  logic                         hitRd,
  input  logic                         hitWr,
  input  logic                         freeRd,
  input  logic                         freeWr,
  input  logic                         rdRetHit,
  input  logic                         wrRetHit,
  input  logic                         agedAny,
  output ctlStrobes_t                  strobes,
  output logic [1:0]                   reqStatus,
  output logic                         reqIllegal,
  output logic                         issueValid,
  output logic                         rspError,
  output logic                         deadlock,
  output logic [OCC_W-1:0]             outCount,
  output logic [AC_NUM-1:0][CNT_W-1:0] aliasCnt
);

  logic             isWr, aliasHit, setFree, full, accept, rdOk, wrOk;
  logic             deadlockQ;
  logic [OCC_W-1:0] countQ, countD;
  logic [AC_NUM-1:0] aliasEvt;
  reqStatus_e       status;

  assign isWr       = isWriteClass(reqType);
  assign reqIllegal = reqValid && ((int'(reqOffset) + int'(reqLen)) > LINE_BYTES);
  assign aliasHit   = hitRd | hitWr;
  assign setFree    = isWr ? freeWr : freeRd;
  assign full       = (int'(countQ) >= MAX_OUT) || !setFree;
  assign accept     = reqValid && !reqIllegal && !aliasHit && !full;

  always_comb begin
    if (!reqValid || reqIllegal) status = ST_NONE;
    else if (aliasHit)           status = ST_ALIASED;
    else if (full)               status = ST_FULL;
    else                         status = ST_ISSUED;
  end

  assign reqStatus  = status;
  assign issueValid = accept;

  assign strobes.allocRd  = accept && !isWr;
  assign strobes.allocWr  = accept && isWr;
  assign strobes.retireRd = rdRspValid;
  assign strobes.retireWr = wrRspValid;

  assign rdOk     = rdRspValid && rdRetHit;
  assign wrOk     = wrRspValid && wrRetHit;
  assign rspError = (rdRspValid && !rdRetHit) || (wrRspValid && !wrRetHit);

  assign countD = countQ + OCC_W'(accept) - OCC_W'(rdOk) - OCC_W'(wrOk);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ    <= '0;
      deadlockQ <= 1'b0;
    end else begin
      countQ    <= countD;
      deadlockQ <= deadlockQ | agedAny;
    end
  end

  assign outCount = countQ;
  assign deadlock = deadlockQ | agedAny;

  // write-class match attributed first
  always_comb begin
    aliasEvt = '0;
    if (reqValid && !reqIllegal && aliasHit) begin
      if (hitWr) aliasEvt[isWr ? AC_WR_ON_WR : AC_RD_ON_WR] = 1'b1;
      else       aliasEvt[isWr ? AC_WR_ON_RD : AC_RD_ON_RD] = 1'b1;
    end
  end

  for (genvar c = 0; c < AC_NUM; c++) begin : gAliasCnt
    logic [CNT_W-1:0] cntQ;
    always_ff @(posedge clk) begin
      if (!rstN)                         cntQ <= '0;
      else if (aliasEvt[c] && cntQ != '1) cntQ <= cntQ + 1'b1;
    end
    assign aliasCnt[c] = cntQ;
  end

  // R3: nothing is issued once the global limit is reached
  p_full_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && int'(outCount) >= MAX_OUT) |-> !issueValid);

  // R4: a fresh issue with no retirement raises the count by one
  p_issue_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !rdRspValid && !wrRspValid) |=> (outCount == $past(outCount) + 1'b1));

  // R8: an unmatched response with nothing else going on leaves the count unchanged
  p_bad_rsp_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspError && !issueValid && !(rdRspValid && wrRspValid)) |=> $stable(outCount));

  // R9: the deadlock flag never falls
  p_deadlock_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    deadlock |=> deadlock);

  // R10: at most one alias counter moves per cycle
  p_one_alias_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(aliasEvt));

endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
  import mtk_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int LINE_BYTES     = 16,
  parameter int LEN_W          = 5,
  parameter int RD_ENTRIES     = 4,
  parameter int WR_ENTRIES     = 4,
  parameter int MAX_OUT        = 6,
  parameter int AGE_W          = 16,
  parameter int DEADLOCK_LIMIT = 200,
  parameter int CNT_W          = 8,
  localparam int OFF_W         = $clog2(LINE_BYTES),
  localparam int LINE_W        = ADDR_W - OFF_W,
  localparam int OCC_W         = $clog2(RD_ENTRIES + WR_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic [1:0]        reqStatus,
  output logic              reqIllegal,
  output logic              issueValid,
  output logic [LINE_W-1:0] issueLine,
  output logic [2:0]        issueType,
  input  logic              rdRspValid,
  input  logic [LINE_W-1:0] rdRspLine,
  input  logic              wrRspValid,
  input  logic [LINE_W-1:0] wrRspLine,
  output logic              rspError,
  output logic              deadlock,
  output logic [OCC_W-1:0]  outCount,
  output logic [CNT_W-1:0]  aliasRdOnWr,
  output logic [CNT_W-1:0]  aliasWrOnWr,
  output logic [CNT_W-1:0]  aliasRdOnRd,
  output logic [CNT_W-1:0]  aliasWrOnRd
);

  ctlStrobes_t                  strobes;
  logic                         hitRd, hitWr, freeRd, freeWr, rdRetHit, wrRetHit, agedAny;
  logic [RD_ENTRIES-1:0]        rdValid;
  logic [WR_ENTRIES-1:0]        wrValid;
  logic [AC_NUM-1:0][CNT_W-1:0] aliasCnt;
  logic [LINE_W-1:0]            reqLine;

  assign reqLine   = reqAddr[ADDR_W-1:OFF_W];
  assign issueLine = reqLine;
  assign issueType = reqType;

  mtk_datapath #(
    .RD_ENTRIES(RD_ENTRIES), .WR_ENTRIES(WR_ENTRIES), .LINE_W(LINE_W),
    .AGE_W(AGE_W), .AGE_LIMIT(DEADLOCK_LIMIT)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqLine(reqLine), .rdRspLine(rdRspLine), .wrRspLine(wrRspLine),
    .hitRd(hitRd), .hitWr(hitWr), .freeRd(freeRd), .freeWr(freeWr),
    .rdRetHit(rdRetHit), .wrRetHit(wrRetHit), .agedAny(agedAny),
    .rdValid(rdValid), .wrValid(wrValid)
  );

  mtk_control #(
    .OFF_W(OFF_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES), .MAX_OUT(MAX_OUT),
    .OCC_W(OCC_W), .CNT_W(CNT_W)
  ) i_control (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqType(reqType), .reqOffset(reqAddr[OFF_W-1:0]), .reqLen(reqLen),
    .rdRspValid(rdRspValid), .wrRspValid(wrRspValid),
    .hitRd(hitRd), .hitWr(hitWr), .freeRd(freeRd), .freeWr(freeWr),
    .rdRetHit(rdRetHit), .wrRetHit(wrRetHit), .agedAny(agedAny),
    .strobes(strobes), .reqStatus(reqStatus), .reqIllegal(reqIllegal),
    .issueValid(issueValid), .rspError(rspError), .deadlock(deadlock),
    .outCount(outCount), .aliasCnt(aliasCnt)
  );

  assign aliasRdOnWr = aliasCnt[AC_RD_ON_WR];
  assign aliasWrOnWr = aliasCnt[AC_WR_ON_WR];
  assign aliasRdOnRd = aliasCnt[AC_RD_ON_RD];
  assign aliasWrOnRd = aliasCnt[AC_WR_ON_RD];

  // R5: the count register and the two sets' live records stay in step
  p_count_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    int'(outCount) == $countones(rdValid) + $countones(wrValid));

  // R6: an illegal request never goes downstream
  p_illegal_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqIllegal |-> (!issueValid && reqStatus == 2'd0));

endmodule

// File: tb/test_miss_tracker.sv
`timescale 1ns/1ps
module test_miss_tracker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqType = '0;
  logic [15:0] reqAddr = '0;
  logic [4:0]  reqLen = '0;
  logic [1:0]  reqStatus;
  logic        reqIllegal, issueValid, rspError, deadlock;
  logic [11:0] issueLine;
  logic [2:0]  issueType;
  logic        rdRspValid = 1'b0, wrRspValid = 1'b0;
  logic [11:0] rdRspLine = '0, wrRspLine = '0;
  logic [3:0]  outCount;
  logic [7:0]  aliasRdOnWr, aliasWrOnWr, aliasRdOnRd, aliasWrOnRd;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  miss_tracker i_miss_tracker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqStatus(reqStatus), .reqIllegal(reqIllegal), .issueValid(issueValid),
    .issueLine(issueLine), .issueType(issueType), .rdRspValid(rdRspValid), .rdRspLine(rdRspLine),
    .wrRspValid(wrRspValid), .wrRspLine(wrRspLine), .rspError(rspError), .deadlock(deadlock),
    .outCount(outCount), .aliasRdOnWr(aliasRdOnWr), .aliasWrOnWr(aliasWrOnWr),
    .aliasRdOnRd(aliasRdOnRd), .aliasWrOnRd(aliasWrOnRd)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {kind(2) 0 req/1 rd rsp/2 wr rsp, type(3), addr(16), len(5), expStatus(2), expErr(1), expCount(4)}
  localparam int NV = 28;
  localparam logic [32:0] VEC [NV] = '{
    {2'd0, 3'd0, 16'h0100, 5'd4,  2'd1, 1'b0, 4'd1},
    {2'd0, 3'd2, 16'h0200, 5'd8,  2'd1, 1'b0, 4'd2},
    {2'd0, 3'd0, 16'h0104, 5'd4,  2'd2, 1'b0, 4'd2},
    {2'd0, 3'd2, 16'h0108, 5'd4,  2'd2, 1'b0, 4'd2},
    {2'd0, 3'd1, 16'h0204, 5'd4,  2'd2, 1'b0, 4'd2},
    {2'd0, 3'd6, 16'h020C, 5'd4,  2'd2, 1'b0, 4'd2},
    {2'd0, 3'd0, 16'h0A0C, 5'd8,  2'd0, 1'b0, 4'd2},
    {2'd1, 3'd0, 16'h0200, 5'd0,  2'd0, 1'b1, 4'd2},
    {2'd2, 3'd0, 16'h0200, 5'd0,  2'd0, 1'b0, 4'd1},
    {2'd2, 3'd0, 16'h0200, 5'd0,  2'd0, 1'b1, 4'd1},
    {2'd0, 3'd1, 16'h0300, 5'd16, 2'd1, 1'b0, 4'd2},
    {2'd0, 3'd3, 16'h0400, 5'd4,  2'd1, 1'b0, 4'd3},
    {2'd0, 3'd4, 16'h0500, 5'd4,  2'd1, 1'b0, 4'd4},
    {2'd0, 3'd5, 16'h0600, 5'd4,  2'd1, 1'b0, 4'd5},
    {2'd0, 3'd6, 16'h0700, 5'd4,  2'd1, 1'b0, 4'd6},
    {2'd0, 3'd2, 16'h0800, 5'd4,  2'd3, 1'b0, 4'd6},
    {2'd0, 3'd0, 16'h0900, 5'd4,  2'd3, 1'b0, 4'd6},
    {2'd1, 3'd0, 16'h0100, 5'd0,  2'd0, 1'b0, 4'd5},
    {2'd1, 3'd0, 16'h0300, 5'd0,  2'd0, 1'b0, 4'd4},
    {2'd0, 3'd2, 16'h0800, 5'd4,  2'd3, 1'b0, 4'd4},
    {2'd0, 3'd0, 16'h0900, 5'd4,  2'd1, 1'b0, 4'd5},
    {2'd2, 3'd0, 16'h0400, 5'd0,  2'd0, 1'b0, 4'd4},
    {2'd0, 3'd2, 16'h0800, 5'd4,  2'd1, 1'b0, 4'd5},
    {2'd1, 3'd0, 16'h0900, 5'd0,  2'd0, 1'b0, 4'd4},
    {2'd2, 3'd0, 16'h0500, 5'd0,  2'd0, 1'b0, 4'd3},
    {2'd2, 3'd0, 16'h0600, 5'd0,  2'd0, 1'b0, 4'd2},
    {2'd2, 3'd0, 16'h0700, 5'd0,  2'd0, 1'b0, 4'd1},
    {2'd2, 3'd0, 16'h0800, 5'd0,  2'd0, 1'b0, 4'd0}
  };

  task automatic clearInputs();
    reqValid = 1'b0; rdRspValid = 1'b0; wrRspValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    clearInputs();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic issueLoad(input logic [15:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqType = 3'd0; reqAddr = a; reqLen = 5'd4;
    @(posedge clk); #1;
    clearInputs();
  endtask

  initial begin : watchdog
    #(20ns * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    #2;
    // R5 R11 reset state
    check("R5 reset count", outCount, 0);
    check("R9 reset deadlock", deadlock, 0);
    check("R11 idle status", reqStatus, 0);
    check("R11 idle issue", issueValid, 0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0]  kind;
      logic [2:0]  typ;
      logic [15:0] addr;
      logic [4:0]  len;
      logic [1:0]  expSt;
      logic        expErr;
      logic [3:0]  expCnt;
      {kind, typ, addr, len, expSt, expErr, expCnt} = VEC[v];
      @(negedge clk);
      if (kind == 2'd0) begin
        reqValid = 1'b1; reqType = typ; reqAddr = addr; reqLen = len;
      end else if (kind == 2'd1) begin
        rdRspValid = 1'b1; rdRspLine = addr[15:4];
      end else begin
        wrRspValid = 1'b1; wrRspLine = addr[15:4];
      end
      #2;
      if (kind == 2'd0) begin
        case (expSt)
          2'd1: check($sformatf("R4 status row %0d", v), reqStatus, 1);
          2'd2: check($sformatf("R2 status row %0d", v), reqStatus, 2);
          2'd3: check($sformatf("R3 status row %0d", v), reqStatus, 3);
          default: begin
            check($sformatf("R6 status row %0d", v), reqStatus, 0);
            check($sformatf("R6 illegal row %0d", v), reqIllegal, 1);
          end
        endcase
        check($sformatf("R4 issue row %0d", v), issueValid, (expSt == 2'd1) ? 1 : 0);
        if (expSt == 2'd1) begin
          check($sformatf("R1 line row %0d", v), issueLine, int'(addr[15:4]));
          check($sformatf("R1 type row %0d", v), issueType, int'(typ));
        end
      end else begin
        check($sformatf("%s err row %0d", expErr ? "R8" : "R7", v), rspError, int'(expErr));
      end
      @(posedge clk); #1;
      check($sformatf("R5 count row %0d", v), outCount, int'(expCnt));
      clearInputs();
    end

    // R10 each alias category hit once in the table
    check("R10 rdOnWr", aliasRdOnWr, 1);
    check("R10 wrOnWr", aliasWrOnWr, 1);
    check("R10 rdOnRd", aliasRdOnRd, 1);
    check("R10 wrOnRd", aliasWrOnRd, 1);
    check("R9 no deadlock yet", deadlock, 0);
    #2;
    check("R11 idle after table", reqStatus, 0);

    // R9 watchdog on one long-lived load
    issueLoad(16'h0A00);
    repeat (150) @(posedge clk);
    #1;
    check("R9 before limit", deadlock, 0);
    repeat (60) @(posedge clk);
    #1;
    check("R9 after limit", deadlock, 1);
    @(negedge clk);
    rdRspValid = 1'b1; rdRspLine = 12'h0A0;
    @(posedge clk); #1;
    clearInputs();
    check("R7 long entry retired", outCount, 0);
    repeat (3) @(posedge clk);
    #1;
    check("R9 sticky", deadlock, 1);

    // R5 reset clears the flag and the sets
    doReset();
    #2;
    check("R5 count after reset", outCount, 0);
    check("R9 cleared by reset", deadlock, 0);
    issueLoad(16'h0A00);
    check("R5 reissue after reset", outCount, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule